// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one timer channel. A counter loads a programmable start value and steps down by one on every tick until it reaches zero. On the tick after zero it loads the start value again and keeps running. A tick comes either from every system clock cycle or from the rising edges of a slow external strobe, which is first brought into the clock domain. Two compare values are checked against the counter as it falls. An event is raised when the counter lands on a compare value, and it can also be raised when the counter reaches zero.

Each event inverts the level of a single interrupt line. The line never gives a one-cycle pulse, so the interrupt controller downstream must detect edges. A simple synchronous write port sets the live count, the start value and the two compare values. One output gives the count as software reads it.

Top module: `dual_match_timer`

## Requirements
- R1: While the channel runs, each tick lowers the count by one, from the start value down to zero.
- R2: On the tick that finds the count at zero, the count loads the start value, as long as the start value is nonzero.
- R3: When `ext_sel` is 0, every clock cycle is a tick. When `ext_sel` is 1, the only ticks are rising edges of `ext_strobe`, each seen through a two-flop synchroniser and acting on the count three clock edges after the strobe rises.
- R4: Every event inverts `irq`. `irq` changes at no other time.
- R5: A tick that steps the count down to a nonzero value equal to either effective compare value raises one event. If both compare values are equal, it still raises only one event.
- R6: A compare value greater than or equal to the start value acts as a compare value of zero.
- R7: A tick that steps the count down to zero raises an event when `ovf_irq_en` is 1 or when either effective compare value is zero. A reload from zero raises no event.
- R8: While the channel is not running, `count_o` shows the start value and `irq` holds its level.
- R9: A write to the count while running loads `wr_data` as the current count on that edge. A write to the count while disabled has no effect. The `wr_sel` codes are 0 for the count, 1 for the start value, 2 for compare A and 3 for compare B.
- R10: With a start value of zero, the running counter stays at zero and raises no events. If a nonzero start value is then written while enabled, the count is loaded with that value on the write edge.
- R11: On the first clock edge with `en` high, the count is loaded from the start value and the channel begins to run. The first tick acts on the following edge.
- R12: A synchronous active-low reset sets the start value, both compare values, the count and `irq` to zero, and stops the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable |
| ext_sel | input | 1 | Tick source: 1 selects the external strobe |
| ovf_irq_en | input | 1 | Raise an event when the count reaches zero |
| ext_strobe | input | 1 | Asynchronous external tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 count, 1 start, 2 compare A, 3 compare B) |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Count as read by software |
| irq | output | 1 | Level-toggling interrupt |

## Verification
The bench uses the default 32-bit width but keeps its start values small, between 3 and 100. This keeps a full count period to a few dozen cycles, so the bench can count `irq` toggles over a whole period, including the wrap back to the start value. Small start values also let the table place compare values above, equal to and below the start value, and set them equal to each other. The external-strobe path is checked with a strobe slow enough to show that the count holds between strobe edges.

// File: rtl/dual_match_timer_pkg.sv
// Package: shared register-select encoding for the dual-match timer.
// Assumes: the write port uses a 2-bit select.
package dual_match_timer_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CMP_A  = 2'd2,
        SEL_CMP_B  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dmt_tick_gen.sv
// Tick generator: picks every-cycle ticks or synchronised rising edges of an
// external strobe. Assumes the strobe stays high and low for longer than
// SYNC_STAGES+1 clock cycles each.
module dmt_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_strobe,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Carry the strobe into the clock domain and keep the last synced value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_strobe};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Choose the tick source
    always_comb begin
        tick = ext_sel ? (sync_q[SYNC_STAGES-1] & ~last_q) : 1'b1;
    end
endmodule

// File: rtl/dmt_regs.sv
// Register store: start value and two compare values, written through the
// synchronous write port. The count itself lives in the top module.
module dmt_regs
    import dual_match_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cmp_a_q,
    output logic [CNT_W-1:0] cmp_b_q
);
    // Store the written value in the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cmp_a_q  <= '0;
            cmp_b_q  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_RELOAD: reload_q <= wr_data;
                SEL_CMP_A:  cmp_a_q  <= wr_data;
                SEL_CMP_B:  cmp_b_q  <= wr_data;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/dmt_event.sv
// Event decoder: decides whether a downward step to next_val raises an event.
// Compare values at or above the start value count as zero. Purely
// combinational.
module dmt_event #(
    parameter int CNT_W = 32
) (
    input  logic             step,
    input  logic [CNT_W-1:0] next_val,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             ovf_en,
    output logic             evt
);
    logic [CNT_W-1:0] eff_a;
    logic [CNT_W-1:0] eff_b;
    logic             zero_hit;

    // Fold out-of-range compare values to zero and decide whether this step fires
    always_comb begin
        eff_a    = (cmp_a < reload) ? cmp_a : '0;
        eff_b    = (cmp_b < reload) ? cmp_b : '0;
        zero_hit = ovf_en || (eff_a == '0) || (eff_b == '0);
        if (!step)
            evt = 1'b0;
        else if (next_val == '0)
            evt = zero_hit;
        else
            evt = (next_val == eff_a) || (next_val == eff_b);
    end
endmodule

// File: rtl/dual_match_timer.sv
// Dual-match down-counting timer channel. Counts from the start value to zero,
// reloads, and inverts irq on each event. Assumes a synchronous active-low
// reset and a single clock domain apart from ext_strobe.
module dual_match_timer
    import dual_match_timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ext_sel,
    input  logic             ovf_irq_en,
    input  logic             ext_strobe,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             tick;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cmp_a_q;
    logic [CNT_W-1:0] cmp_b_q;
    logic             step;
    logic             evt;
    logic             wr_count;
    logic             wr_start;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(wr_sel);

    dmt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_sel    (ext_sel),
        .ext_strobe (ext_strobe),
        .tick       (tick)
    );

    dmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .reload_q (reload_q),
        .cmp_a_q  (cmp_a_q),
        .cmp_b_q  (cmp_b_q)
    );

    // Decode the count write and the start-from-zero write
    always_comb begin
        wr_count = wr_en && (sel == SEL_COUNT);
        wr_start = wr_en && (sel == SEL_RELOAD) && (reload_q == '0) && (wr_data != '0);
    end

    // Choose the next count; only a downward step can raise an event
    always_comb begin
        cnt_d = cnt_q;
        step  = 1'b0;
        if (en) begin
            if (!run_q)
                cnt_d = reload_q;
            else if (wr_count)
                cnt_d = wr_data;
            else if (wr_start)
                cnt_d = wr_data;
            else if (tick) begin
                if (cnt_q == '0)
                    cnt_d = reload_q;
                else begin
                    cnt_d = cnt_q - ONE;
                    step  = 1'b1;
                end
            end
        end
    end

    dmt_event #(.CNT_W(CNT_W)) u_evt (
        .step     (step),
        .next_val (cnt_d),
        .reload   (reload_q),
        .cmp_a    (cmp_a_q),
        .cmp_b    (cmp_b_q),
        .ovf_en   (ovf_irq_en),
        .evt      (evt)
    );

    // Hold the count, the run flag and the interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= en;
            if (evt)
                irq <= ~irq;
        end
    end

    // Software view: the start value while stopped
    always_comb begin
        count_o = run_q ? cnt_q : reload_q;
    end
endmodule

// File: rtl/dual_match_timer_chk.sv
// Checker for dual_match_timer, attached with bind. Observes ports plus the
// run flag and the stored start value.
module dual_match_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ext_sel,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_o,
    input logic             irq,
    input logic             run_q,
    input logic [CNT_W-1:0] reload
);
    // With every-cycle ticks and no write, a running nonzero count falls by one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && !ext_sel && !wr_en && count_o != '0)
        |=> (count_o == $past(count_o) - 1'b1));

    // With every-cycle ticks, a count of zero wraps to the start value
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && !ext_sel && !wr_en && count_o == '0 && reload != '0)
        |=> (count_o == $past(reload)));

    // No event can occur while the enable is low
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(irq));

    // A count write while running lands in the count
    assert_count_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run_q && wr_en && wr_sel == 2'd0) |=> (count_o == $past(wr_data)));

    // Enabling loads the start value on the next edge
    assert_enable_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run_q && !wr_en) |=> (run_q && count_o == $past(reload)));

    // Reset clears the level and the start value
    assert_reset_clear_R12: assert property (@(posedge clk)
        (!rst_n) |=> (irq == 1'b0 && reload == '0));
endmodule

bind dual_match_timer dual_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ext_sel (ext_sel),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .count_o (count_o),
    .irq     (irq),
    .run_q   (run_q),
    .reload  (reload_q)
);

// File: tb/dual_match_timer_bench.sv
`timescale 1ns/1ps
module dual_match_timer_bench;
    localparam int CNT_W = 32;
    localparam real HALF = 2.5;

    // columns: start, cmp A, cmp B, overflow enable, expected toggles per period
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{5, 3, 1, 0, 2},
        '{5, 3, 1, 1, 3},
        '{5, 2, 2, 0, 1},
        '{5, 7, 2, 0, 2},
        '{5, 5, 0, 0, 1},
        '{8, 0, 6, 0, 2},
        '{3, 1, 2, 1, 3},
        '{4, 9, 9, 0, 1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             ext_sel = 1'b0;
    logic             ovf_irq_en = 1'b0;
    logic             ext_strobe = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] count_o;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    dual_match_timer #(.CNT_W(CNT_W)) u_dual_match_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .ext_sel(ext_sel),
        .ovf_irq_en(ovf_irq_en), .ext_strobe(ext_strobe), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .count_o(count_o), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [CNT_W-1:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Run cycles, returning how often irq changed
    task automatic run_count(input int n, output int toggles);
        logic prev;
        toggles = 0;
        prev = irq;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq !== prev) toggles++;
            prev = irq;
        end
    endtask

    initial begin
        int tg;
        int r;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(count_o == 0, "R12 count at reset", count_o, 0);
        check(irq == 1'b0, "R12 irq at reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: stopped readout shows the start value
        write_reg(2'd1, 9);
        check(count_o == 9, "R8 stopped readout", count_o, 9);
        // R9: count write while stopped ignored
        write_reg(2'd0, 77);
        check(count_o == 9, "R9 stopped count write ignored", count_o, 9);
        en = 1'b1;
        @(negedge clk);
        check(count_o == 9, "R11 enable loads start value", count_o, 9);
        @(negedge clk);
        check(count_o == 8, "R1 first tick", count_o, 8);
        en = 1'b0;
        @(negedge clk);

        // Table: one full period per vector, covering R1 R2 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            r = VEC[v][0];
            write_reg(2'd1, CNT_W'(r));
            write_reg(2'd2, CNT_W'(VEC[v][1]));
            write_reg(2'd3, CNT_W'(VEC[v][2]));
            ovf_irq_en = VEC[v][3][0];
            en = 1'b1;
            run_count(r + 2, tg);
            check(tg == VEC[v][4], $sformatf("R4 R5 R6 R7 toggles vector %0d", v), tg, VEC[v][4]);
            check(count_o == CNT_W'(r), $sformatf("R2 wrap vector %0d", v), count_o, r);
            en = 1'b0;
            run_count(3, tg);
            check(tg == 0, "R8 irq holds while stopped", tg, 0);
        end

        // R9: count write while running
        write_reg(2'd1, 100);
        ovf_irq_en = 1'b0;
        en = 1'b1;
        repeat (4) @(negedge clk);
        write_reg(2'd0, 50);
        check(count_o == 50, "R9 running count write", count_o, 50);
        @(negedge clk);
        check(count_o == 49, "R9 step after write", count_o, 49);
        en = 1'b0;
        @(negedge clk);

        // R10: zero start value idles, then a nonzero write starts it
        write_reg(2'd1, 0);
        ovf_irq_en = 1'b1;
        en = 1'b1;
        run_count(6, tg);
        check(count_o == 0, "R10 idle at zero", count_o, 0);
        check(tg == 0, "R10 no events at zero", tg, 0);
        write_reg(2'd1, 6);
        check(count_o == 6, "R10 start from zero", count_o, 6);
        @(negedge clk);
        check(count_o == 5, "R10 counting after start", count_o, 5);
        en = 1'b0;
        ovf_irq_en = 1'b0;
        @(negedge clk);

        // R3: external strobe ticks
        ext_sel = 1'b1;
        write_reg(2'd1, 20);
        en = 1'b1;
        repeat (12) @(negedge clk);
        check(count_o == 20, "R3 no tick without strobe", count_o, 20);
        for (int p = 0; p < 3; p++) begin
            ext_strobe = 1'b1;
            repeat (4) @(negedge clk);
            ext_strobe = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(count_o == 17, "R3 three strobe ticks", count_o, 17);
        ext_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(count_o == 17, "R3 synchroniser delay", count_o, 17);
        @(negedge clk);
        check(count_o == 16, "R3 tick after sync", count_o, 16);
        ext_strobe = 1'b0;
        ext_sel = 1'b0;

        // R12: reset while running
        write_reg(2'd2, 5);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(count_o == 0, "R12 reset clears count", count_o, 0);
        check(irq == 1'b0, "R12 reset clears irq", irq, 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule